// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shifter

This block is an eight-stage shift register that takes a byte in parallel and sends it out one bit at a time. It runs entirely inside one fast system clock domain. All of its pins are sampled as ordinary synchronous inputs. These pins are a slow shift-clock pin, a clock-inhibit pin, an active-low load pin, a serial input and eight parallel data inputs. The stages are named A to H. Parallel bit 0 feeds stage A and parallel bit 7 feeds stage H.

While the load pin is low, the register copies the parallel inputs every cycle. While the load pin is high, the register can only shift or hold. The shift clock is the logical OR of the shift-clock pin and the inhibit pin, and each low-to-high transition of that merged level gives exactly one shift toward H. On each shift, stage A takes the serial input. So if inhibit is raised while the shift clock is low, that transition itself counts as a shift. The block reproduces this on purpose.

Every pin passes through a two-register synchronizer before it is used, so a change on a pin reaches the outputs three system-clock cycles later. The outputs are stage H and its complement.

Top module: `psr_shifter`

## Requirements
- R1: A synchronous active-high reset clears all stages to 0, so `q_out`=0 and `qn_out`=1. The pin levels present when reset is released do not cause a shift, even with the shift-clock pin held high.
- R2: While `load_n_pin` is low, stage k takes `par_pin[k]` every cycle. Bit 0 goes to stage A and bit 7 goes to stage H, which drives `q_out`.
- R3: A low `load_n_pin` wins over a merged-clock rising edge that arrives in the same cycle. The loaded byte is taken unchanged and the serial input has no effect.
- R4: A shift loads stage A from `ser_pin` and loads each stage k from stage k-1. After a load of byte b, eight shifts bring bits b[6] down to b[0] and then the first serial bit to `q_out`.
- R5: While `inhibit_pin` is high, toggling `sclk_pin` causes no shift and all stages hold.
- R6: With `load_n_pin` high, each low-to-high transition of (`sclk_pin` OR `inhibit_pin`) gives exactly one shift. Holding the merged level high, or letting it fall, gives no shift.
- R7: If `inhibit_pin` rises while `sclk_pin` is low and `load_n_pin` is high, this gives exactly one shift.
- R8: `qn_out` is always the complement of `q_out`.
- R9: When `load_n_pin` returns high with no new merged edge, the register keeps the last loaded byte and does not shift in that cycle.
- R10: A pin change applied just after a clock edge reaches the outputs after three rising clock edges (two synchronizer stages plus the register). After two edges the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_pin | input | 1 | Slow shift-clock pin |
| inhibit_pin | input | 1 | Clock-inhibit pin, merged with `sclk_pin` by OR |
| load_n_pin | input | 1 | Active-low parallel load, level-sensitive |
| ser_pin | input | 1 | Serial data entering stage A |
| par_pin | input | 8 | Parallel data, bit 0 to stage A, bit 7 to stage H |
| q_out | output | 1 | Stage H |
| qn_out | output | 1 | Complement of stage H |

## Verification
Two functions can meet in one cycle. The first pair is a parallel load and a merged-clock rising edge. The bench provokes this by pulling the load pin low in the same cycle that the shift-clock pin rises, with the serial pin set to the opposite value. It then shifts the whole byte out: every bit must match the parallel byte, with no trace of the serial bit. The second pair is the inhibit function and the clock function. Inhibit rising while the shift clock is low must give one shift, which is judged on the next serial bit. Shift-clock toggles while inhibit is high must leave the output stream unchanged.

// File: rtl/psr_pkg.sv
package psr_pkg;

    parameter int unsigned PSR_WIDTH       = 8;
    parameter int unsigned PSR_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } psr_op_e;

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
    parameter int unsigned    W       = 1,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pipe[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.pipe <= {STAGES{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign d_out = s_q.pipe[STAGES-1];

endmodule

// File: rtl/psr_edge.sv
module psr_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic inh_s,
    output logic rise
);

    typedef struct packed {
        logic hist;
    } edge_t;

    edge_t e_d, e_q;
    logic  merged;

    always_comb begin
        merged     = sclk_s | inh_s;
        rise       = merged & ~e_q.hist;
        e_d        = e_q;
        e_d.hist   = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q.hist <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);                                   // R6
    AST_INHIBIT_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (inh_s && $past(inh_s)) |-> !rise);                // R5

endmodule

// File: rtl/psr_core.sv
module psr_core #(
    parameter int unsigned W = psr_pkg::PSR_WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  psr_pkg::psr_op_e  op,
    input  logic              ser,
    input  logic [W-1:0]      par,
    output logic [W-1:0]      stages
);
    import psr_pkg::*;

    typedef struct packed {
        logic [W-1:0] st;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (op)
            OP_LOAD:  c_d.st = par;
            OP_SHIFT: c_d.st = {c_q.st[W-2:0], ser};
            default:  c_d.st = c_q.st;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.st <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign stages = c_q.st;

    AST_LOAD_TRACKS_PAR: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (stages == $past(par)));       // R2
    AST_SHIFT_MOVES_DATA: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (stages == {$past(stages[W-2:0]), $past(ser)})); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(stages));              // R9

endmodule

// File: rtl/psr_shifter.sv
module psr_shifter #(
    parameter int unsigned W           = psr_pkg::PSR_WIDTH,
    parameter int unsigned SYNC_STAGES = psr_pkg::PSR_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk_pin,
    input  logic         inhibit_pin,
    input  logic         load_n_pin,
    input  logic         ser_pin,
    input  logic [W-1:0] par_pin,
    output logic         q_out,
    output logic         qn_out
);
    import psr_pkg::*;

    localparam int unsigned CTL_W  = 3;
    localparam int unsigned DATA_W = W + 1;

    logic [CTL_W-1:0]  ctl_s;
    logic [DATA_W-1:0] data_s;
    logic              sclk_s, inh_s, load_n_s, ser_s;
    logic [W-1:0]      par_s;
    logic              rise;
    psr_op_e           op;
    logic [W-1:0]      stages;

    // Control pins reset to the idle-high level so release makes no edge.
    psr_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({sclk_pin, inhibit_pin, load_n_pin}),
        .d_out (ctl_s)
    );

    // Data pins share the same latency so they stay aligned with load.
    psr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({ser_pin, par_pin}),
        .d_out (data_s)
    );

    always_comb begin
        sclk_s   = ctl_s[2];
        inh_s    = ctl_s[1];
        load_n_s = ctl_s[0];
        ser_s    = data_s[W];
        par_s    = data_s[W-1:0];
    end

    psr_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (sclk_s),
        .inh_s  (inh_s),
        .rise   (rise)
    );

    always_comb begin
        if (!load_n_s) begin
            op = OP_LOAD;
        end else if (rise) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

    psr_core #(.W(W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ser    (ser_s),
        .par    (par_s),
        .stages (stages)
    );

    assign q_out  = stages[W-1];
    assign qn_out = ~stages[W-1];

    AST_OUTPUTS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        q_out != qn_out);                                  // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $fell(rst) |-> (stages == '0));                    // R1
    AST_LOAD_BEATS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!load_n_s && rise) |=> (stages == $past(par_s))); // R3

endmodule

// File: tb/psr_shifter_tb_top.sv
module psr_shifter_tb_top;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       sclk  = 1'b1;
    logic       inh   = 1'b0;
    logic       ld_n  = 1'b1;
    logic       ser   = 1'b1;
    logic [7:0] par   = 8'h00;
    logic       q, qn;

    typedef struct {
        logic  q;
        logic  qn;
        string tag;
    } exp_t;

    exp_t       exp_q[$];
    int         n_chk  = 0;
    int         n_bad  = 0;
    logic [7:0] ref_r  = 8'h00;
    logic       prev_m = 1'b1;
    logic       done   = 1'b0;

    always #2 clk = ~clk;

    psr_shifter dut_i (
        .clk         (clk),
        .rst         (rst),
        .sclk_pin    (sclk),
        .inhibit_pin (inh),
        .load_n_pin  (ld_n),
        .ser_pin     (ser),
        .par_pin     (par),
        .q_out       (q),
        .qn_out      (qn)
    );

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            n_chk++;
            if (q !== e.q || qn !== e.qn) begin
                n_bad++;
                $display("FAIL %s: actual q=%b qn=%b expected q=%b qn=%b",
                         e.tag, q, qn, e.q, e.qn);
            end
        end
    end

    task automatic expect_now(input string tag);
        exp_t e;
        e.q   = ref_r[7];
        e.qn  = ~ref_r[7];
        e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    // Driver: applies one pin state, advances the reference model, checks.
    task automatic step(input logic c, input logic i, input logic l,
                        input logic s, input logic [7:0] p, input string tag);
        logic m;
        @(negedge clk);
        sclk = c; inh = i; ld_n = l; ser = s; par = p;
        m = c | i;
        if (!l)                 ref_r = p;
        else if (m && !prev_m)  ref_r = {ref_r[6:0], s};
        prev_m = m;
        repeat (4) @(posedge clk);
        @(negedge clk);
        expect_now(tag);
    endtask

    task automatic shift_out8(input string tag);
        for (int k = 0; k < 8; k++) begin
            logic b;
            b = 1'($urandom);
            step(1'b1, 1'b0, 1'b1, b, par, tag);
            step(1'b0, 1'b0, 1'b1, b, par, {tag, " fall-hold R6"});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_now("R1 reset value R8");

        // R1: no shift at release with sclk held high; a spurious one would
        // push ser=1 into stage A and reach H after seven more shifts.
        for (int k = 0; k < 7; k++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R1 fall");
            step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R1 no shift after reset");
        end

        // R2: parallel load
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, "R2 load A5");
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, "R2 load 5A");
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, "R2 reload A5");

        // R10: latency of a parallel change
        @(negedge clk);
        par = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect_now("R10 old value after two edges");
        @(posedge clk);
        @(negedge clk);
        ref_r = 8'h00;
        expect_now("R10 new value after three edges");

        // R4/R6/R9: random bytes loaded and shifted out
        for (int n = 0; n < 3; n++) begin
            logic [7:0] rb;
            rb = 8'($urandom);
            step(1'b0, 1'b0, 1'b0, 1'b0, rb, "R2 random load");
            step(1'b0, 1'b0, 1'b1, 1'b0, rb, "R9 load release hold");
            shift_out8("R4 R6 shift");
        end

        // R5: inhibit high blocks clock toggles
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, "R2 load 3C");
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, "R9 release");
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, "R6 shift");
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, "R5 inhibit raised with clock high");
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, "R5 hold clock low");
            step(1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, "R5 hold clock high");
        end

        // R7: inhibit rising while clock low gives one shift
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, "R6 merged fall hold");
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, "R7 inhibit edge shifts");
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, "R7 fall hold");
        step(1'b0, 1'b1, 1'b1, 1'b0, 8'h3C, "R7 second inhibit edge");

        // R3: load together with a merged rising edge
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, "R6 idle");
        step(1'b1, 1'b0, 1'b0, 1'b1, 8'h96, "R3 load beats edge");
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h96, "R3 R9 release");
        shift_out8("R3 R4 verify byte");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule